// File: doc/BRIEF.md
# Delayed Lockstep Redundancy Checker

This block is the comparison boundary of a two-core delayed-lockstep safety pair. The main core works on shared resources directly: the system bus, a single local data-memory array, and the controller in front of that array. The checker core never touches them. Every read return from the shared side goes to the main core at once. The block hands the same return to the checker core two clock cycles later, so the checker core runs the same program two cycles behind the main core.

In the other direction, a copy of each main-core output group enters a matching delay pipeline of the same depth. The block compares that delayed copy with the output the checker core produces in the current cycle. The output groups are compared separately, each in its own channel with its own fault line toward the fault collection logic:

- the bus group;
- the memory-array interface group;
- an auxiliary core output group;
- the memory-controller group.

The memory array is shared, but each core has its own controller path to it, and the controller path is checked on its own channel. A channel reports a one-cycle event pulse and also holds a sticky fault flag until it is cleared. A per-channel fault-injection input corrupts one bit of the checker-side value so that the detection path itself can be exercised.

Top module: `lsc_top`

## Requirements
- R1: The read return (`rd_vld_i`, `rd_dat_i`) appears unchanged on `chk_rd_vld_o` and `chk_rd_dat_o` exactly DELAY (default 2) cycles later. The checker-core outputs feed only the comparators, and no port of the block carries them toward a shared resource.
- R2: When the checker core presents, DELAY cycles later, the same valid and payload that the main core presented, no channel raises an event or a fault.
- R3: Channel indices in every per-channel vector are fixed: 0 is the bus group, 1 the memory-array interface, 2 the auxiliary core group, 3 the memory-controller group. Payload layouts, most significant field first, are as follows. Bus: {address AW, write data DW, byte enables DW/8, write enable}. Memory array: {address MAW, write data DW, byte enables DW/8, write enable}. Auxiliary: AUX_W bits. Memory controller: {address MAW, byte enables DW/8, write enable}. When both sides are valid, a difference in any single payload bit raises `evt_o` for that channel only, visible after the clock edge at which the checker value is sampled.
- R4: A disagreement between the delayed main valid and the checker valid of a channel is a mismatch, whatever the payloads hold.
- R5: While both the delayed main valid and the checker valid of a channel are low, payload contents and fault injection on that channel have no effect.
- R6: `evt_o[i]` is high for exactly one cycle per mismatching compare and falls in the next cycle if the next compare matches.
- R7: `fault_o[i]` is set by a mismatch and stays set until `clr_i[i]` is high at a clock edge. A mismatch in the same cycle as a clear leaves the flag set.
- R8: After reset, the compares at the first DELAY clock edges are suppressed, so no event or fault can arise while the pipelines fill.
- R9: With both sides valid and equal, `inj_i[i]` high inverts payload bit INJ_BIT of channel i on the checker side and so produces a mismatch on that channel.
- R10: Synchronous active-high `rst` clears both delay pipelines, all events and all fault flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_vld_i | input | 1 | Read-return valid from shared resources |
| rd_dat_i | input | DW | Read-return data from shared resources |
| chk_rd_vld_o | output | 1 | Delayed read valid to checker core |
| chk_rd_dat_o | output | DW | Delayed read data to checker core |
| m_vld_i | input | 4 | Main-core valid per channel |
| m_bus_i | input | AW+DW+DW/8+1 | Main-core bus payload |
| m_marr_i | input | MAW+DW+DW/8+1 | Main-core memory-array payload |
| m_aux_i | input | AUX_W | Main-core auxiliary payload |
| m_mctl_i | input | MAW+DW/8+1 | Main-core memory-controller payload |
| c_vld_i | input | 4 | Checker-core valid per channel |
| c_bus_i | input | AW+DW+DW/8+1 | Checker-core bus payload |
| c_marr_i | input | MAW+DW+DW/8+1 | Checker-core memory-array payload |
| c_aux_i | input | AUX_W | Checker-core auxiliary payload |
| c_mctl_i | input | MAW+DW/8+1 | Checker-core memory-controller payload |
| inj_i | input | 4 | Per-channel fault injection |
| clr_i | input | 4 | Per-channel sticky-flag clear |
| evt_o | output | 4 | One-cycle mismatch event per channel |
| fault_o | output | 4 | Sticky mismatch flag per channel |

## Verification
The bench builds the block with AW=8, DW=8, MAW=4, AUX_W=4, DELAY=2 and INJ_BIT=0. This gives channel payloads of 18, 14, 4 and 6 bits. At that size every single payload bit of every channel can be flipped in turn, so the sweep shows that each bit reaches its own channel's comparator and no other. The same small widths keep the valid-disagreement, masked-idle, injection and clear/set-collision cases short enough to run on every channel. The bench also repeats the reset warm-up in the middle of the run.

// File: rtl/lsc_pkg.sv
package lsc_pkg;
   localparam int NCH     = 4;
   localparam int CH_BUS  = 0;
   localparam int CH_MARR = 1;
   localparam int CH_AUX  = 2;
   localparam int CH_MCTL = 3;

   function automatic int bus_w(input int aw, input int dw);
      return aw + dw + dw / 8 + 1;
   endfunction

   function automatic int marr_w(input int maw, input int dw);
      return maw + dw + dw / 8 + 1;
   endfunction

   function automatic int mctl_w(input int maw, input int dw);
      return maw + dw / 8 + 1;
   endfunction
endpackage

// File: rtl/lsc_delay.sv
module lsc_delay #(
   parameter int W = 1,
   parameter int D = 2
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   if (D == 1) begin : g_single
      logic [W-1:0] q_r;
      always_ff @(posedge clk) begin
         if (rst) q_r <= '0;
         else     q_r <= d_i;
      end
      assign q_o = q_r;
   end else begin : g_chain
      logic [W-1:0] st_r [D];
      always_ff @(posedge clk) begin
         if (rst) begin
            for (int i = 0; i < D; i++) st_r[i] <= '0;
         end else begin
            st_r[0] <= d_i;
            for (int i = 1; i < D; i++) st_r[i] <= st_r[i-1];
         end
      end
      assign q_o = st_r[D-1];
   end
endmodule

// File: rtl/lsc_chan.sv
module lsc_chan #(
   parameter int W       = 8,
   parameter int INJ_BIT = 0
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         cmp_en_i,
   input  logic         m_vld_i,
   input  logic [W-1:0] m_pl_i,
   input  logic         c_vld_i,
   input  logic [W-1:0] c_pl_i,
   input  logic         inj_i,
   input  logic         clr_i,
   output logic         evt_o,
   output logic         fault_o
);
   logic [W-1:0] flip_mask;
   logic [W-1:0] c_eff;
   logic         vld_diff;
   logic         pl_diff;
   logic         miss;
   logic         evt_r;
   logic         flag_r;

   assign flip_mask = W'(inj_i) << INJ_BIT;
   assign c_eff     = c_pl_i ^ flip_mask;
   assign vld_diff  = m_vld_i ^ c_vld_i;
   // payload only counts when both sides claim a transfer
   assign pl_diff   = m_vld_i & c_vld_i & (m_pl_i != c_eff);
   assign miss      = cmp_en_i & (vld_diff | pl_diff);

   always_ff @(posedge clk) begin
      if (rst) begin
         evt_r  <= 1'b0;
         flag_r <= 1'b0;
      end else begin
         evt_r  <= miss;
         flag_r <= (flag_r & ~clr_i) | miss;
      end
   end

   assign evt_o   = evt_r;
   assign fault_o = flag_r;
endmodule

// File: rtl/lsc_top.sv
module lsc_top
   import lsc_pkg::*;
#(
   parameter int AW      = 32,
   parameter int DW      = 32,
   parameter int MAW     = 16,
   parameter int AUX_W   = 8,
   parameter int DELAY   = 2,
   parameter int INJ_BIT = 0,
   localparam int BUS_W  = bus_w(AW, DW),
   localparam int MARR_W = marr_w(MAW, DW),
   localparam int MCTL_W = mctl_w(MAW, DW)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              rd_vld_i,
   input  logic [DW-1:0]     rd_dat_i,
   output logic              chk_rd_vld_o,
   output logic [DW-1:0]     chk_rd_dat_o,
   input  logic [NCH-1:0]    m_vld_i,
   input  logic [BUS_W-1:0]  m_bus_i,
   input  logic [MARR_W-1:0] m_marr_i,
   input  logic [AUX_W-1:0]  m_aux_i,
   input  logic [MCTL_W-1:0] m_mctl_i,
   input  logic [NCH-1:0]    c_vld_i,
   input  logic [BUS_W-1:0]  c_bus_i,
   input  logic [MARR_W-1:0] c_marr_i,
   input  logic [AUX_W-1:0]  c_aux_i,
   input  logic [MCTL_W-1:0] c_mctl_i,
   input  logic [NCH-1:0]    inj_i,
   input  logic [NCH-1:0]    clr_i,
   output logic [NCH-1:0]    evt_o,
   output logic [NCH-1:0]    fault_o
);
   localparam int TOT_W = BUS_W + MARR_W + AUX_W + MCTL_W;
   localparam int CHW [NCH] = '{BUS_W, MARR_W, AUX_W, MCTL_W};
   localparam int CHO [NCH] = '{0, BUS_W, BUS_W + MARR_W, BUS_W + MARR_W + AUX_W};
   localparam int WC_W = $clog2(DELAY + 1);

   // elaboration-time parameter checks
   if (DELAY < 1) begin : g_bad_delay
      $error("lsc_top: DELAY must be at least 1");
   end
   if (DW % 8 != 0 || DW < 8) begin : g_bad_dw
      $error("lsc_top: DW must be a nonzero multiple of 8");
   end
   if (AW < 1 || MAW < 1 || AUX_W < 1) begin : g_bad_w
      $error("lsc_top: address and auxiliary widths must be positive");
   end

   // read return path toward the checker core
   logic [DW:0] rd_q;
   lsc_delay #(.W(DW + 1), .D(DELAY)) u_rd_dly (
      .clk (clk),
      .rst (rst),
      .d_i ({rd_vld_i, rd_dat_i}),
      .q_o (rd_q)
   );
   assign chk_rd_vld_o = rd_q[DW];
   assign chk_rd_dat_o = rd_q[DW-1:0];

   // warm-up: compares stay off while pipelines fill
   logic [WC_W-1:0] warm_cnt;
   logic            cmp_en;
   always_ff @(posedge clk) begin
      if (rst)                             warm_cnt <= '0;
      else if (warm_cnt != WC_W'(DELAY))   warm_cnt <= warm_cnt + 1'b1;
   end
   assign cmp_en = (warm_cnt == WC_W'(DELAY));

   logic [TOT_W-1:0] m_flat;
   logic [TOT_W-1:0] c_flat;
   assign m_flat = {m_mctl_i, m_aux_i, m_marr_i, m_bus_i};
   assign c_flat = {c_mctl_i, c_aux_i, c_marr_i, c_bus_i};

   for (genvar g = 0; g < NCH; g++) begin : g_ch
      localparam int W = CHW[g];
      localparam int O = CHO[g];

      if (INJ_BIT >= W) begin : g_bad_inj
         $error("lsc_top: INJ_BIT exceeds a channel width");
      end

      logic [W:0] m_dly;
      lsc_delay #(.W(W + 1), .D(DELAY)) u_m_dly (
         .clk (clk),
         .rst (rst),
         .d_i ({m_vld_i[g], m_flat[O +: W]}),
         .q_o (m_dly)
      );

      lsc_chan #(.W(W), .INJ_BIT(INJ_BIT)) u_cmp (
         .clk      (clk),
         .rst      (rst),
         .cmp_en_i (cmp_en),
         .m_vld_i  (m_dly[W]),
         .m_pl_i   (m_dly[W-1:0]),
         .c_vld_i  (c_vld_i[g]),
         .c_pl_i   (c_flat[O +: W]),
         .inj_i    (inj_i[g]),
         .clr_i    (clr_i[g]),
         .evt_o    (evt_o[g]),
         .fault_o  (fault_o[g])
      );
   end
endmodule

// File: rtl/lsc_sva.sv
module lsc_sva
   import lsc_pkg::*;
#(
   parameter int DELAY = 2
) (
   input logic           clk,
   input logic           rst,
   input logic           rd_vld_i,
   input logic           chk_rd_vld_o,
   input logic [NCH-1:0] m_vld_i,
   input logic [NCH-1:0] c_vld_i,
   input logic [NCH-1:0] clr_i,
   input logic [NCH-1:0] evt_o,
   input logic [NCH-1:0] fault_o
);
   localparam int CW = $clog2(DELAY + 2);

   logic [CW-1:0]  cyc;
   logic           rd_h  [DELAY];
   logic [NCH-1:0] mv_h  [DELAY];

   always_ff @(posedge clk) begin
      if (rst) begin
         cyc <= '0;
         for (int i = 0; i < DELAY; i++) begin
            rd_h[i] <= 1'b0;
            mv_h[i] <= '0;
         end
      end else begin
         if (cyc != CW'(DELAY + 1)) cyc <= cyc + 1'b1;
         rd_h[0] <= rd_vld_i;
         mv_h[0] <= m_vld_i;
         for (int i = 1; i < DELAY; i++) begin
            rd_h[i] <= rd_h[i-1];
            mv_h[i] <= mv_h[i-1];
         end
      end
   end

   assert_rd_delay_R1: assert property (@(posedge clk) disable iff (rst)
      chk_rd_vld_o == rd_h[DELAY-1]);

   assert_warmup_quiet_R8: assert property (@(posedge clk) disable iff (rst)
      (cyc <= CW'(DELAY)) |-> (evt_o == '0));

   for (genvar g = 0; g < NCH; g++) begin : g_chk
      assert_vld_disagree_R4: assert property (@(posedge clk) disable iff (rst)
         (cyc >= CW'(DELAY) && c_vld_i[g] != mv_h[DELAY-1][g]) |=> evt_o[g]);

      assert_idle_masked_R5: assert property (@(posedge clk) disable iff (rst)
         (!c_vld_i[g] && !mv_h[DELAY-1][g]) |=> !evt_o[g]);

      assert_evt_sets_flag_R6: assert property (@(posedge clk) disable iff (rst)
         evt_o[g] |-> fault_o[g]);

      assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (rst)
         (fault_o[g] && !clr_i[g]) |=> fault_o[g]);
   end
endmodule

bind lsc_top lsc_sva #(.DELAY(DELAY)) u_lsc_sva (
   .clk          (clk),
   .rst          (rst),
   .rd_vld_i     (rd_vld_i),
   .chk_rd_vld_o (chk_rd_vld_o),
   .m_vld_i      (m_vld_i),
   .c_vld_i      (c_vld_i),
   .clr_i        (clr_i),
   .evt_o        (evt_o),
   .fault_o      (fault_o)
);

// File: tb/tb_lsc_top.sv
module tb_lsc_top;
   import lsc_pkg::*;

   localparam int AW = 8, DW = 8, MAW = 4, AUX_W = 4, DELAY = 2, INJ_BIT = 0;
   localparam int BUS_W  = AW + DW + DW / 8 + 1;
   localparam int MARR_W = MAW + DW + DW / 8 + 1;
   localparam int MCTL_W = MAW + DW / 8 + 1;
   localparam int CW [NCH] = '{BUS_W, MARR_W, AUX_W, MCTL_W};

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic              rst;
   logic              rd_vld_i;
   logic [DW-1:0]     rd_dat_i;
   logic              chk_rd_vld_o;
   logic [DW-1:0]     chk_rd_dat_o;
   logic [NCH-1:0]    m_vld_i, c_vld_i, inj_i, clr_i, evt_o, fault_o;
   logic [31:0]       mp [NCH];
   logic [31:0]       cp [NCH];

   lsc_top #(.AW(AW), .DW(DW), .MAW(MAW), .AUX_W(AUX_W), .DELAY(DELAY), .INJ_BIT(INJ_BIT)) dut (
      .clk(clk), .rst(rst),
      .rd_vld_i(rd_vld_i), .rd_dat_i(rd_dat_i),
      .chk_rd_vld_o(chk_rd_vld_o), .chk_rd_dat_o(chk_rd_dat_o),
      .m_vld_i(m_vld_i),
      .m_bus_i(mp[0][BUS_W-1:0]), .m_marr_i(mp[1][MARR_W-1:0]),
      .m_aux_i(mp[2][AUX_W-1:0]), .m_mctl_i(mp[3][MCTL_W-1:0]),
      .c_vld_i(c_vld_i),
      .c_bus_i(cp[0][BUS_W-1:0]), .c_marr_i(cp[1][MARR_W-1:0]),
      .c_aux_i(cp[2][AUX_W-1:0]), .c_mctl_i(cp[3][MCTL_W-1:0]),
      .inj_i(inj_i), .clr_i(clr_i), .evt_o(evt_o), .fault_o(fault_o)
   );

   int n_chk = 0, n_bad = 0, cyc = 0;
   bit done = 0;
   logic [NCH-1:0] h1v, h2v, exp_evt, exp_flag;
   logic [31:0]    h1p [NCH];
   logic [31:0]    h2p [NCH];
   logic [DW:0]    rd_last;

   function automatic logic [31:0] wmask(input int w);
      return (w >= 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
   endfunction

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic do_reset();
      rst = 1'b1;
      m_vld_i = '0; c_vld_i = '0; inj_i = '0; clr_i = '0;
      rd_vld_i = 1'b0; rd_dat_i = '0;
      for (int c = 0; c < NCH; c++) begin mp[c] = '0; cp[c] = '0; h1p[c] = '0; h2p[c] = '0; end
      h1v = '0; h2v = '0; exp_evt = '0; exp_flag = '0; rd_last = '0; cyc = 0;
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      chk("R10", "evt after reset", 32'(evt_o), 32'd0);
      chk("R10", "fault after reset", 32'(fault_o), 32'd0);
      chk("R10", "read path after reset", 32'({chk_rd_vld_o, chk_rd_dat_o}), 32'd0);
   endtask

   // one cycle: main drives new values, checker replays main from DELAY cycles ago
   task automatic step(input string req, input logic [NCH-1:0] mvn, input logic [NCH-1:0] flipv,
                       input logic [NCH-1:0] flipp, input int fbit,
                       input logic [NCH-1:0] inj, input logic [NCH-1:0] clr);
      logic [NCH-1:0] diff;
      logic [31:0]    ce;
      logic [DW:0]    rd_prev;
      rd_prev = rd_last;
      m_vld_i = mvn;
      c_vld_i = h2v ^ flipv;
      inj_i = inj; clr_i = clr;
      for (int c = 0; c < NCH; c++) begin
         mp[c] = $urandom() & wmask(CW[c]);
         cp[c] = h2p[c] ^ ((flipp[c] && fbit < CW[c]) ? (32'd1 << fbit) : 32'd0);
         ce = (cp[c] ^ (inj[c] ? (32'd1 << INJ_BIT) : 32'd0)) & wmask(CW[c]);
         diff[c] = (c_vld_i[c] != h2v[c]) || (c_vld_i[c] && h2v[c] && ce != h2p[c]);
      end
      rd_vld_i = 1'($urandom());
      rd_dat_i = DW'($urandom());
      rd_last = {rd_vld_i, rd_dat_i};
      exp_evt  = (cyc >= DELAY) ? diff : '0;
      exp_flag = (exp_flag & ~clr) | exp_evt;
      h2v = h1v; h1v = mvn;
      for (int c = 0; c < NCH; c++) begin h2p[c] = h1p[c]; h1p[c] = mp[c]; end
      cyc++;
      @(negedge clk);
      chk(req, "evt", 32'(evt_o), 32'(exp_evt));
      chk(req, "fault", 32'(fault_o), 32'(exp_flag));
      // R1: read return seen DELAY cycles after it was driven
      chk("R1", "checker read", 32'({chk_rd_vld_o, chk_rd_dat_o}), 32'(rd_prev));
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      do_reset();
      // R8: disagreements during the fill phase are ignored
      step("R8", 4'hF, 4'hF, 4'hF, 0, 4'h0, 4'h0);
      step("R8", 4'hF, 4'hF, 4'hF, 1, 4'h0, 4'h0);
      // R2: clean replay with random valids and payloads
      for (int i = 0; i < 24; i++) step("R2", NCH'($urandom()), 4'h0, 4'h0, 0, 4'h0, 4'h0);
      step("R2", 4'hF, 4'h0, 4'h0, 0, 4'h0, 4'h0);
      step("R2", 4'hF, 4'h0, 4'h0, 0, 4'h0, 4'h0);
      // R3 sweep over every payload bit of every channel, then R6 pulse end, R7 clear
      for (int c = 0; c < NCH; c++) begin
         for (int b = 0; b < CW[c]; b++) begin
            step("R3", 4'hF, 4'h0, NCH'(1 << c), b, 4'h0, 4'h0);
            step("R6", 4'hF, 4'h0, 4'h0, 0, 4'h0, 4'h0);
            step("R7", 4'hF, 4'h0, 4'h0, 0, 4'h0, 4'hF);
         end
      end
      // R4: valid disagreement in both directions
      for (int c = 0; c < NCH; c++) begin
         step("R4", 4'hF, NCH'(1 << c), 4'h0, 0, 4'h0, 4'h0);
         step("R7", 4'hF, 4'h0, 4'h0, 0, 4'h0, 4'hF);
      end
      step("R4", 4'h0, 4'h0, 4'h0, 0, 4'h0, 4'h0);
      step("R4", 4'h0, 4'h0, 4'h0, 0, 4'h0, 4'h0);
      step("R4", 4'h0, 4'h5, 4'hF, 2, 4'h0, 4'h0);
      step("R7", 4'h0, 4'h0, 4'h0, 0, 4'h0, 4'hF);
      // R5: both sides idle, payload and injection are ignored
      for (int i = 0; i < 4; i++) step("R5", 4'h0, 4'h0, 4'hF, i, 4'hF, 4'h0);
      // R9: injection on each channel with equal valid traffic
      step("R9", 4'hF, 4'h0, 4'h0, 0, 4'h0, 4'h0);
      step("R9", 4'hF, 4'h0, 4'h0, 0, 4'h0, 4'h0);
      for (int c = 0; c < NCH; c++) begin
         step("R9", 4'hF, 4'h0, 4'h0, 0, NCH'(1 << c), 4'h0);
         step("R7", 4'hF, 4'h0, 4'h0, 0, 4'h0, 4'hF);
      end
      // R7: a mismatch in the clear cycle keeps the flag set
      step("R7", 4'hF, 4'h0, 4'b0101, 0, 4'h0, 4'hF);
      step("R7", 4'hF, 4'h0, 4'h0, 0, 4'h0, 4'h0);
      step("R7", 4'hF, 4'h0, 4'h0, 0, 4'h0, 4'hF);
      // R10: reset in mid-run with flags set, then a fresh warm-up (R8)
      step("R10", 4'hF, 4'hF, 4'h0, 0, 4'h0, 4'h0);
      do_reset();
      step("R8", 4'h0, 4'hF, 4'h0, 0, 4'h0, 4'h0);
      step("R8", 4'h0, 4'hA, 4'h0, 0, 4'h0, 4'h0);
      step("R2", 4'h0, 4'h0, 4'h0, 0, 4'h0, 4'h0);
      step("R4", 4'h0, 4'h3, 4'h0, 0, 4'h0, 4'h0);
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule